// File: doc/BRIEF.md
# Two-Compare Set/Clear PWM Output Stage

This block drives the output pin of one timer channel. It compares the channel's free-running count against two compare values, A and B. In PWM mode, an equality with A drives the pin high and an equality with B drives it low. Compare value A therefore places the leading edge of each pulse, and compare value B places the trailing edge. The period and the duty come from the counter and from the two compare values. No duty comparator is involved.

A PWM-enable bit selects this behaviour. A separate two-bit combined-mode field can override the enable: when it selects one of the combined waveform modes, this stage ignores the enable and keeps the pin on its normal compare-output function. In that function the pin toggles on each A match, starting from a software-chosen idle level. Both compare events also set sticky flags in every mode. A write-one strobe clears each flag.

Top module: `pwm_setclr_out`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pin_out`, `flag_a` and `flag_b` are 0 after that edge.
- R2: PWM mode is active when `pwm_en` is 1 and `combo_mode[1]` is 0, so combined-mode codes 2'b00 and 2'b01 both keep PWM mode available.
- R3: In PWM mode, a cycle where `cnt == cmp_a` and `cnt != cmp_b` makes `pin_out` 1 after the next clock edge.
- R4: In PWM mode, a cycle where `cnt == cmp_b` makes `pin_out` 0 after the next clock edge.
- R5: In PWM mode, when `cnt` equals both compare values in the same cycle, the clear wins and `pin_out` is 0 after the next edge.
- R6: `combo_mode` values 2'b10 (complementary) and 2'b11 (reset-synchronized) override `pwm_en`. The pin then follows the normal compare-output function.
- R7: In normal mode, `pin_out` inverts on the edge after each cycle with `cnt == cmp_a`, and holds otherwise. Matches with `cmp_b` have no effect on the pin.
- R8: After reset, the normal-mode level starts at `idle_level`. `pin_out` shows that level from the first edge after reset release, unless an A match occurs in that cycle.
- R9: On entry into PWM mode the PWM level is 0 until the first A or B match.
- R10: `flag_a` and `flag_b` are set on the edge after a cycle with an A or B match, in any mode. Each stays set until its clear strobe is 1 in a cycle with no match. A match in the same cycle as the clear strobe wins.
- R11: In PWM mode, a cycle with no match leaves `pin_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt | input | CNT_W | Channel counter value |
| cmp_a | input | CNT_W | Compare value A (set edge in PWM mode) |
| cmp_b | input | CNT_W | Compare value B (clear edge in PWM mode) |
| pwm_en | input | 1 | PWM-mode enable |
| combo_mode | input | 2 | Combined-mode field; bit 1 set overrides `pwm_en` |
| idle_level | input | 1 | Normal-mode level loaded during reset |
| clr_flag_a | input | 1 | Write-one clear strobe for `flag_a` |
| clr_flag_b | input | 1 | Write-one clear strobe for `flag_b` |
| pin_out | output | 1 | Registered channel output pin |
| flag_a | output | 1 | Sticky A compare-match flag |
| flag_b | output | 1 | Sticky B compare-match flag |

## Verification
A corrupted PWM level shows on `pin_out` at most one edge after it occurs. It persists until the next A or B match repairs it, which happens within one counter period. A wrong normal-mode level is never repaired by a later toggle. The pin therefore stays inverted against the expected waveform from that cycle onward, so the level is compared on every cycle of sweeps over all pairs of compare values. A mis-set or lost flag is visible on the flag port one edge later and stays wrong until the next clear or match.

// File: rtl/pwm_setclr_pkg.sv
// Package: shared types and helpers for the two-compare PWM output stage.
// Assumes the combined-mode field is two bits wide; bit 1 flags an
// overriding combined waveform mode.
package pwm_setclr_pkg;

    // Combined-mode field encodings seen by this channel.
    typedef enum logic [1:0] {
        CMB_INDEP = 2'b00,
        CMB_SYNC  = 2'b01,
        CMB_COMPL = 2'b10,
        CMB_RSYNC = 2'b11
    } combo_e;

    // Index of each compare channel inside the match vectors.
    localparam int unsigned IDX_A  = 0;
    localparam int unsigned IDX_B  = 1;
    localparam int unsigned N_CMP  = 2;

    // True when the combined-mode field takes the pin away from PWM mode.
    function automatic logic combo_overrides(input combo_e m);
        return (m == CMB_COMPL) || (m == CMB_RSYNC);
    endfunction

endpackage

// File: rtl/pwm_cmp_bank.sv
// Module: bank of equality comparators, one per compare register.
// Assumes compare values arrive packed, entry k in bits [k].
module pwm_cmp_bank #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned N     = 2
) (
    input  logic [CNT_W-1:0]        cnt,
    input  logic [N-1:0][CNT_W-1:0] cmp,
    output logic [N-1:0]            hit
);

    // One comparator per compare register.
    for (genvar k = 0; k < N; k++) begin : g_cmp
        assign hit[k] = (cnt == cmp[k]);
    end

endmodule

// File: rtl/pwm_mode_dec.sv
// Module: decodes PWM enable and combined-mode field into the active mode.
// Assumes both inputs are stable register bits for the cycle.
module pwm_mode_dec
    import pwm_setclr_pkg::*;
(
    input  logic       pwm_en,
    input  logic [1:0] combo_mode,
    output logic       pwm_act,
    output logic       override
);

    combo_e mode_v;

    // Resolve precedence: combined modes beat the PWM enable.
    always_comb begin
        mode_v   = combo_e'(combo_mode);
        override = combo_overrides(mode_v);
        pwm_act  = pwm_en && !override;
    end

endmodule

// File: rtl/pwm_match_flags.sv
// Module: sticky compare-match flags with write-one clear strobes.
// Assumes a set event and a clear strobe in the same cycle resolve to set.
module pwm_match_flags #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hit,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);

    for (genvar k = 0; k < N; k++) begin : g_flag
        logic flag_q;
        // Hold each flag until cleared; a match takes priority.
        always_ff @(posedge clk) begin
            if (!rst_n)      flag_q <= 1'b0;
            else if (hit[k]) flag_q <= 1'b1;
            else if (clr[k]) flag_q <= 1'b0;
        end
        assign flag[k] = flag_q;
    end

endmodule

// File: rtl/pwm_wave_core.sv
// Module: produces the pin level for PWM and normal compare-output modes.
// Assumes set_hit/clr_hit are same-cycle compare equalities; the pin is
// registered so every change lands on the edge after the match.
module pwm_wave_core (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_act,
    input  logic set_hit,
    input  logic clr_hit,
    input  logic idle_level,
    output logic pin
);

    logic pwm_q, pwm_d;
    logic norm_q, norm_d;
    logic pin_q;

    // Next PWM level: cleared outside PWM mode, clear beats set.
    always_comb begin
        if (!pwm_act)     pwm_d = 1'b0;
        else if (clr_hit) pwm_d = 1'b0;
        else if (set_hit) pwm_d = 1'b1;
        else              pwm_d = pwm_q;
    end

    // Next normal level: toggle on A match only while not in PWM mode.
    always_comb begin
        norm_d = norm_q;
        if (!pwm_act && set_hit) norm_d = !norm_q;
    end

    // Hold PWM level register.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= pwm_d;
    end

    // Hold normal level register, loaded with the idle level in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) norm_q <= idle_level;
        else        norm_q <= norm_d;
    end

    // Register the pin from the active mode's next level.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pwm_act ? pwm_d : norm_d;
    end

    assign pin = pin_q;

endmodule

// File: rtl/pwm_setclr_out.sv
// Module: two-compare set/clear PWM output stage for one timer channel.
// Assumes cnt is the channel's counter; compare and control values are
// software registers held outside this block.
module pwm_setclr_out
    import pwm_setclr_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic             pwm_en,
    input  logic [1:0]       combo_mode,
    input  logic             idle_level,
    input  logic             clr_flag_a,
    input  logic             clr_flag_b,
    output logic             pin_out,
    output logic             flag_a,
    output logic             flag_b
);

    logic [N_CMP-1:0][CNT_W-1:0] cmp_vec;
    logic [N_CMP-1:0]            hit;
    logic [N_CMP-1:0]            clr_vec;
    logic [N_CMP-1:0]            flag_vec;
    logic                        pwm_act;
    logic                        override;

    // Pack the compare values and clear strobes by channel index.
    always_comb begin
        cmp_vec[IDX_A] = cmp_a;
        cmp_vec[IDX_B] = cmp_b;
        clr_vec[IDX_A] = clr_flag_a;
        clr_vec[IDX_B] = clr_flag_b;
    end

    pwm_cmp_bank #(.CNT_W(CNT_W), .N(N_CMP)) u_cmp (
        .cnt (cnt),
        .cmp (cmp_vec),
        .hit (hit)
    );

    pwm_mode_dec u_mode (
        .pwm_en     (pwm_en),
        .combo_mode (combo_mode),
        .pwm_act    (pwm_act),
        .override   (override)
    );

    pwm_wave_core u_wave (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwm_act    (pwm_act),
        .set_hit    (hit[IDX_A]),
        .clr_hit    (hit[IDX_B]),
        .idle_level (idle_level),
        .pin        (pin_out)
    );

    pwm_match_flags #(.N(N_CMP)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .clr   (clr_vec),
        .flag  (flag_vec)
    );

    assign flag_a = flag_vec[IDX_A];
    assign flag_b = flag_vec[IDX_B];

    logic unused_override;
    assign unused_override = override;

endmodule

// File: rtl/pwm_setclr_out_chk.sv
// Module: port-level checker for pwm_setclr_out, attached with bind.
// Assumes the same parameters as the checked instance.
module pwm_setclr_out_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp_a,
    input logic [CNT_W-1:0] cmp_b,
    input logic             pwm_en,
    input logic [1:0]       combo_mode,
    input logic             clr_flag_a,
    input logic             clr_flag_b,
    input logic             pin_out,
    input logic             flag_a,
    input logic             flag_b
);

    logic act, ma, mb;
    logic was_norm, was_act;

    // Observe mode and matches from the ports.
    always_comb begin
        act = pwm_en && !combo_mode[1];
        ma  = (cnt == cmp_a);
        mb  = (cnt == cmp_b);
    end

    // Remember the previous cycle's mode, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            was_norm <= 1'b0;
            was_act  <= 1'b0;
        end else begin
            was_norm <= !act;
            was_act  <= act;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!pin_out && !flag_a && !flag_b));

    a_r3_set_on_a: assert property (@(posedge clk) disable iff (!rst_n)
        (act && ma && !mb) |=> pin_out);

    a_r4_clear_on_b: assert property (@(posedge clk) disable iff (!rst_n)
        (act && mb && !ma) |=> !pin_out);

    a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (act && ma && mb) |=> !pin_out);

    a_r7_toggle_on_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && was_norm && ma) |=> (pin_out != $past(pin_out)));

    a_r7_hold_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && was_norm && !ma) |=> $stable(pin_out));

    a_r9_entry_low: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !was_act && !ma && !mb) |=> !pin_out);

    a_r11_hold_pwm: assert property (@(posedge clk) disable iff (!rst_n)
        (act && was_act && !ma && !mb) |=> $stable(pin_out));

    a_r10_flag_a_set: assert property (@(posedge clk) disable iff (!rst_n)
        ma |=> flag_a);

    a_r10_flag_b_set: assert property (@(posedge clk) disable iff (!rst_n)
        mb |=> flag_b);

    a_r10_flag_a_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_a && !clr_flag_a) |=> flag_a);

    a_r10_flag_b_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_b && !clr_flag_b) |=> flag_b);

endmodule

bind pwm_setclr_out pwm_setclr_out_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt        (cnt),
    .cmp_a      (cmp_a),
    .cmp_b      (cmp_b),
    .pwm_en     (pwm_en),
    .combo_mode (combo_mode),
    .clr_flag_a (clr_flag_a),
    .clr_flag_b (clr_flag_b),
    .pin_out    (pin_out),
    .flag_a     (flag_a),
    .flag_b     (flag_b)
);

// File: tb/test_pwm_setclr_out.sv
`timescale 1ns/1ps
module test_pwm_setclr_out;

    localparam int W = 4;
    localparam int SPAN = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt = '0;
    logic [W-1:0] cmp_a = '0;
    logic [W-1:0] cmp_b = '0;
    logic         pwm_en = 1'b0;
    logic [1:0]   combo_mode = 2'b00;
    logic         idle_level = 1'b0;
    logic         clr_flag_a = 1'b0;
    logic         clr_flag_b = 1'b0;
    logic         pin_out, flag_a, flag_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench model state.
    logic m_pwm, m_norm, m_pin, m_fa, m_fb, m_prev_act, m_fresh;

    always #2.5 clk = ~clk;

    pwm_setclr_out #(.CNT_W(W)) i_pwm_setclr_out (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .pwm_en(pwm_en), .combo_mode(combo_mode), .idle_level(idle_level),
        .clr_flag_a(clr_flag_a), .clr_flag_b(clr_flag_b),
        .pin_out(pin_out), .flag_a(flag_a), .flag_b(flag_b)
    );

    task automatic chk(input string tag, input string what, input logic act_v, input logic exp_v);
        n_cmp++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b (t=%0t)", tag, what, act_v, exp_v, $time);
        end
    endtask

    // Drive one cycle at the falling edge, advance the model, compare.
    task automatic step(input logic [W-1:0] c, input logic ca, input logic cb);
        logic act, ma, mb;
        string tag;
        cnt = c; clr_flag_a = ca; clr_flag_b = cb;
        act = pwm_en && !combo_mode[1];
        ma = (c == cmp_a);
        mb = (c == cmp_b);
        if (act) begin
            if (combo_mode == 2'b01) tag = "R2";
            else if (ma && mb)       tag = "R5";
            else if (mb)             tag = "R4";
            else if (ma)             tag = "R3";
            else if (!m_prev_act)    tag = "R9";
            else                     tag = "R11";
        end else begin
            if (m_fresh && !ma)               tag = "R8";
            else if (pwm_en && combo_mode[1]) tag = "R6";
            else                              tag = "R7";
        end
        @(posedge clk);
        if (!act) m_pwm = 1'b0;
        else if (mb) m_pwm = 1'b0;
        else if (ma) m_pwm = 1'b1;
        if (!act && ma) m_norm = !m_norm;
        m_pin = act ? m_pwm : m_norm;
        m_fa = ma ? 1'b1 : (ca ? 1'b0 : m_fa);
        m_fb = mb ? 1'b1 : (cb ? 1'b0 : m_fb);
        m_prev_act = act;
        m_fresh = 1'b0;
        @(negedge clk);
        chk(tag, "pin_out", pin_out, m_pin);
        chk("R10", "flag_a", flag_a, m_fa);
        chk("R10", "flag_b", flag_b, m_fb);
        clr_flag_a = 1'b0; clr_flag_b = 1'b0;
    endtask

    task automatic do_reset(input logic idle);
        idle_level = idle;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1", "pin_out", pin_out, 1'b0);
        chk("R1", "flag_a", flag_a, 1'b0);
        chk("R1", "flag_b", flag_b, 1'b0);
        rst_n = 1'b1;
        m_pwm = 1'b0; m_norm = idle; m_pin = 1'b0;
        m_fa = 1'b0; m_fb = 1'b0; m_prev_act = 1'b0; m_fresh = 1'b1;
    endtask

    // Sweep all pairs of compare values over a full counter period each.
    task automatic sweep(input logic en, input logic [1:0] cm);
        pwm_en = en; combo_mode = cm;
        for (int a = 0; a < SPAN; a++) begin
            for (int b = 0; b < SPAN; b++) begin
                cmp_a = W'(a); cmp_b = W'(b);
                for (int c = 0; c < SPAN; c++) step(W'(c), (c % 5) == 0, (c % 7) == 0);
            end
        end
    endtask

    initial begin
        do_reset(1'b0);
        // R8: first cycles after reset show idle level in normal mode.
        cmp_a = 4'd9; cmp_b = 4'd2;
        step(4'd0, 1'b0, 1'b0);
        do_reset(1'b1);
        step(4'd0, 1'b0, 1'b0);
        step(4'd1, 1'b0, 1'b0);
        // R9/R3/R4/R5/R11: PWM mode over every compare pair.
        sweep(1'b1, 2'b00);
        // R2: combined-mode code 01 keeps PWM mode.
        do_reset(1'b0);
        pwm_en = 1'b1; combo_mode = 2'b01; cmp_a = 4'd3; cmp_b = 4'd11;
        for (int c = 0; c < SPAN; c++) step(W'(c), 1'b0, 1'b0);
        // R7: normal mode toggles on A only.
        do_reset(1'b1);
        sweep(1'b0, 2'b00);
        // R6: both overriding codes with PWM enabled.
        do_reset(1'b0);
        sweep(1'b1, 2'b10);
        do_reset(1'b1);
        pwm_en = 1'b1; combo_mode = 2'b11; cmp_a = 4'd4; cmp_b = 4'd4;
        for (int c = 0; c < 2 * SPAN; c++) step(W'(c % SPAN), 1'b0, 1'b0);
        // R9: re-enter PWM mode after normal mode; level starts at 0.
        combo_mode = 2'b00; cmp_a = 4'd12; cmp_b = 4'd14;
        step(4'd1, 1'b0, 1'b0);
        step(4'd2, 1'b0, 1'b0);
        // R10: sticky flag, clear, and match-beats-clear.
        cmp_a = 4'd6; cmp_b = 4'd8;
        step(4'd6, 1'b0, 1'b0);
        step(4'd0, 1'b0, 1'b0);
        step(4'd0, 1'b0, 1'b0);
        step(4'd0, 1'b1, 1'b0);
        step(4'd8, 1'b0, 1'b1);
        step(4'd6, 1'b1, 1'b1);
        step(4'd0, 1'b1, 1'b1);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule